// File: doc/BRIEF.md
# RGMII Transmit Encoder

This block turns a byte-wide transmit stream into the reduced-pin, double-data-rate transmit side of RGMII. On each rising clock edge it samples one data byte, a transmit-enable flag and a transmit-error flag. It then drives a 4-bit data bus and one control line. The data bus carries the low nibble while the clock is high and the high nibble while it is low.

The control line does not carry the error flag as a plain bit. During the high phase it shows enable. During the low phase it shows enable XOR error. Because of this coding, the control line stays constant through a clean frame and through idle, and it toggles only when an error or an extension is signalled.

A speed-select input chooses between gigabit operation, with one byte per clock, and the 10/100 Mb/s mode. In the 10/100 mode each clock carries one nibble, and the same low nibble appears in both phases. The two-edge output stage is behavioural: a per-bit multiplexer selected by the clock level.

Top module: `rgmii_tx_enc`

## Requirements
- R1: While the clock is high after rising edge k, `rgmii_d_o` equals bits 3:0 of the byte sampled at edge k, whenever enable or error was set at that edge.
- R2: With `gig_mode_i`=1, while the clock is low after edge k, `rgmii_d_o` equals bits 7:4 of the byte sampled at edge k, whenever enable or error was set.
- R3: While the clock is high after edge k, `rgmii_ctl_o` equals the enable flag sampled at edge k.
- R4: While the clock is low after edge k, `rgmii_ctl_o` equals enable XOR error as sampled at edge k. A clean frame therefore gives high/high and idle gives low/low.
- R5: With `gig_mode_i`=0, both phases of a cycle carry bits 3:0 of the sampled byte.
- R6: When enable and error are both 0 at a rising edge, `rgmii_d_o` is 0 in both phases of that cycle, whatever the byte is.
- R7: While `rst_ni` is low, `rgmii_d_o` and `rgmii_ctl_o` are 0 in both clock phases, and reset takes effect without a clock edge.
- R8: The low phase uses the same byte, enable and error sampled at the preceding rising edge. Input changes during the high phase have no effect until the next rising edge.
- R9: With enable 0 and error 1, control is low in the high phase and high in the low phase, and the data byte is passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit clock (125, 25 or 2.5 MHz by link speed) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gig_mode_i | input | 1 | 1: byte per clock; 0: nibble per clock (10/100) |
| txd_i | input | 8 | Transmit data byte |
| tx_en_i | input | 1 | Transmit enable |
| tx_err_i | input | 1 | Transmit error |
| rgmii_d_o | output | 4 | DDR data nibble |
| rgmii_ctl_o | output | 1 | DDR control: enable when high, enable XOR error when low |

## Verification
The assertions assume that the byte, enable, error and speed-select inputs are steady around each rising edge. Under that assumption, the registered halves they compare against depend only on the previous edge's inputs. The bench keeps to this by changing inputs only on falling edges or a few nanoseconds after a rising edge, never at the rising edge itself. It also samples outputs in the middle of each phase. From those samples it rebuilds the byte, enable and error, covering all four enable/error combinations in both speed modes.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;
  typedef struct packed {
    logic en;
    logic err;
  } tx_ctl_t;
endpackage

// File: rtl/rgmii_tx_capture.sv
module rgmii_tx_capture
  import rgmii_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_ctl_t           ctl_i,
  output logic [NIB_W-1:0]  rise_data_o,
  output logic [NIB_W-1:0]  fall_data_o,
  output tx_ctl_t           ctl_o
);
  logic             active;
  logic [NIB_W-1:0] lo_nib, hi_nib;

  assign active = ctl_i.en | ctl_i.err;
  assign lo_nib = data_i[NIB_W-1:0];
  // nibble mode repeats low half on the falling phase
  assign hi_nib = gig_mode_i ? data_i[DATA_W-1:NIB_W] : lo_nib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_data_o <= '0;
      fall_data_o <= '0;
      ctl_o       <= '0;
    end else begin
      rise_data_o <= active ? lo_nib : '0;
      fall_data_o <= active ? hi_nib : '0;
      ctl_o       <= ctl_i;
    end
  end
endmodule

// File: rtl/rgmii_tx_ctl_enc.sv
module rgmii_tx_ctl_enc
  import rgmii_tx_pkg::*;
(
  input  tx_ctl_t ctl_i,
  output logic    ctl_rise_o,
  output logic    ctl_fall_o
);
  assign ctl_rise_o = ctl_i.en;
  assign ctl_fall_o = ctl_i.en ^ ctl_i.err;
endmodule

// File: rtl/rgmii_ddr_out.sv
module rgmii_ddr_out #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] q_o
);
  // behavioural two-edge output: high phase shows rise half
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i] = clk_i ? rise_i[i] : fall_i[i];
  end
endmodule

// File: rtl/rgmii_tx_enc.sv
module rgmii_tx_enc
  import rgmii_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_mode_i,
  input  logic [DATA_W-1:0] txd_i,
  input  logic              tx_en_i,
  input  logic              tx_err_i,
  output logic [NIB_W-1:0]  rgmii_d_o,
  output logic              rgmii_ctl_o
);
  tx_ctl_t          ctl_in, ctl_q;
  logic [NIB_W-1:0] rise_data, fall_data;
  logic             ctl_rise, ctl_fall;

  assign ctl_in.en  = tx_en_i;
  assign ctl_in.err = tx_err_i;

  rgmii_tx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gig_mode_i  (gig_mode_i),
    .data_i      (txd_i),
    .ctl_i       (ctl_in),
    .rise_data_o (rise_data),
    .fall_data_o (fall_data),
    .ctl_o       (ctl_q)
  );

  rgmii_tx_ctl_enc u_enc (
    .ctl_i      (ctl_q),
    .ctl_rise_o (ctl_rise),
    .ctl_fall_o (ctl_fall)
  );

  rgmii_ddr_out #(.W(NIB_W)) u_ddr_d (
    .clk_i  (clk_i),
    .rise_i (rise_data),
    .fall_i (fall_data),
    .q_o    (rgmii_d_o)
  );

  rgmii_ddr_out #(.W(1)) u_ddr_c (
    .clk_i  (clk_i),
    .rise_i (ctl_rise),
    .fall_i (ctl_fall),
    .q_o    (rgmii_ctl_o)
  );
endmodule

// File: rtl/rgmii_tx_enc_chk.sv
module rgmii_tx_enc_chk #(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gig_mode_i,
  input logic [DATA_W-1:0] txd_i,
  input logic              tx_en_i,
  input logic              tx_err_i,
  input logic [NIB_W-1:0]  rise_data,
  input logic [NIB_W-1:0]  fall_data,
  input logic              ctl_rise,
  input logic              ctl_fall
);
  assert_rise_nibble_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i || tx_err_i) |=> rise_data == $past(txd_i[NIB_W-1:0]));

  assert_fall_nibble_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gig_mode_i && (tx_en_i || tx_err_i)) |=> fall_data == $past(txd_i[DATA_W-1:NIB_W]));

  assert_ctl_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ctl_rise == $past(tx_en_i));

  assert_ctl_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ctl_fall == $past(tx_en_i ^ tx_err_i));

  assert_nibble_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gig_mode_i && (tx_en_i || tx_err_i)) |=> fall_data == $past(txd_i[NIB_W-1:0]));

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !tx_err_i) |=> (rise_data == '0 && fall_data == '0));

  assert_extend_ctl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && tx_err_i) |=> (!ctl_rise && ctl_fall));
endmodule

bind rgmii_tx_enc rgmii_tx_enc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gig_mode_i (gig_mode_i),
  .txd_i      (txd_i),
  .tx_en_i    (tx_en_i),
  .tx_err_i   (tx_err_i),
  .rise_data  (rise_data),
  .fall_data  (fall_data),
  .ctl_rise   (ctl_rise),
  .ctl_fall   (ctl_fall)
);

// File: tb/sim_rgmii_tx_enc.sv
`timescale 1ns/1ps
module sim_rgmii_tx_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gig = 1'b1;
  logic [7:0] txd = '0;
  logic       en = 1'b0, err = 1'b0;
  logic [3:0] d_o;
  logic       c_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rgmii_tx_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .gig_mode_i(gig), .txd_i(txd),
    .tx_en_i(en), .tx_err_i(err), .rgmii_d_o(d_o), .rgmii_ctl_o(c_o)
  );

  // {gig, en, err, byte}
  localparam logic [10:0] VEC [11] = '{
    {1'b1,1'b1,1'b0,8'hA5}, {1'b1,1'b1,1'b0,8'h3C}, {1'b1,1'b1,1'b1,8'hF0},
    {1'b1,1'b0,1'b1,8'h0F}, {1'b1,1'b0,1'b0,8'hFF}, {1'b0,1'b1,1'b0,8'hB7},
    {1'b0,1'b1,1'b1,8'h4E}, {1'b0,1'b0,1'b0,8'h99}, {1'b0,1'b0,1'b1,8'h62},
    {1'b1,1'b1,1'b0,8'h00}, {1'b1,1'b1,1'b0,8'hFF}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [3:0] r_d, f_d;
  logic       r_c, f_c;

  // sample mid high phase then mid low phase of the cycle after next posedge
  task automatic sample_cycle();
    @(posedge clk); #5; r_d = d_o; r_c = c_o;
    @(negedge clk); #5; f_d = d_o; f_c = c_o;
  endtask

  task automatic expect_cycle(input logic g, input logic e, input logic x, input logic [7:0] b);
    bit act = e | x;
    logic [3:0] er = act ? b[3:0] : 4'h0;
    logic [3:0] ef = act ? (g ? b[7:4] : b[3:0]) : 4'h0;
    chk(r_d == er, act ? "R1 rise nibble" : "R6 idle rise", {4'h0, r_d}, {4'h0, er});
    chk(f_d == ef, !act ? "R6 idle fall" : (g ? "R2 fall nibble" : "R5 nibble mode"), {4'h0, f_d}, {4'h0, ef});
    chk(r_c == e, "R3 ctl rise", {7'h0, r_c}, {7'h0, e});
    chk(f_c == (e ^ x), "R4 ctl fall", {7'h0, f_c}, {7'h0, e ^ x});
    // rebuild flags from the line
    chk((r_c ^ f_c) == x, "R4 rebuilt error", {7'h0, r_c ^ f_c}, {7'h0, x});
    if (g && act) chk({f_d, r_d} == b, "R2 rebuilt byte", {f_d, r_d}, b);
    if (!e && x) chk(!r_c && f_c && {f_d, r_d} == (g ? b : {b[3:0], b[3:0]}),
                     "R9 extension", {6'h0, r_c, f_c}, 8'h01);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog act=%h exp=%h", 8'h0, 8'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state in both phases
    @(posedge clk); #5;
    chk(d_o == 0 && c_o == 0, "R7 reset high phase", {3'h0, c_o, d_o}, 8'h00);
    @(negedge clk); #5;
    chk(d_o == 0 && c_o == 0, "R7 reset low phase", {3'h0, c_o, d_o}, 8'h00);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < 11; i++) begin
      {gig, en, err, txd} = VEC[i];
      sample_cycle();
      expect_cycle(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R8: change inputs during high phase, low phase keeps sampled byte
    gig = 1'b1; en = 1'b1; err = 1'b0; txd = 8'h5A;
    @(posedge clk); #2;
    txd = 8'hC3; err = 1'b1; en = 1'b0;
    #3; r_d = d_o; r_c = c_o;
    @(negedge clk); #5; f_d = d_o; f_c = c_o;
    chk({f_d, r_d} == 8'h5A, "R8 hold byte", {f_d, r_d}, 8'h5A);
    chk(r_c && f_c, "R8 hold ctl", {6'h0, r_c, f_c}, 8'h03);
    sample_cycle();
    expect_cycle(1'b1, 1'b0, 1'b1, 8'hC3);

    // R7: asynchronous reset mid-frame, low phase
    en = 1'b1; err = 1'b0; txd = 8'hEE;
    @(posedge clk); #15;
    rst_n = 1'b0; #1;
    chk(d_o == 0 && c_o == 0, "R7 async reset", {3'h0, c_o, d_o}, 8'h00);
    @(posedge clk); #5;
    chk(d_o == 0 && c_o == 0, "R7 reset held high", {3'h0, c_o, d_o}, 8'h00);
    @(negedge clk); #2; rst_n = 1'b1;
    sample_cycle();
    expect_cycle(1'b1, 1'b1, 1'b0, 8'hEE);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule